// File: doc/BRIEF.md
# Serial Flash Status and Write Guard

This block keeps the status byte of a small serial flash and decides, one command at a time, whether a write-class command may start. The command decoder hands it single-cycle strobes for set-enable, clear-enable, status write, page program and erase, along with the target byte address and the data byte of a status write. The guard weighs each request against the write-enable latch, the block-protect level and the hardware-protect condition. The hardware-protect condition is formed from the active-low protect pin and a protect-enable bit held in the register.

When a request is granted, one bit of a three-bit permit vector pulses for a single cycle, and the write sequencer is expected to raise its busy flag. From the grant until busy drops, the block counts as busy: it ignores every strobe and the status byte reads as all ones. When busy drops, the enable latch clears itself. A status write stores its new protection fields at the moment of the grant. A change of the protect pin after the grant therefore cannot alter that write.

Top module: `fsr_guard`

## Requirements
- R1: After reset the status byte reads 0x00, the permit vector is 000, and the protect outputs hold their reset parameters, which are zero by default.
- R2: While idle the status byte is {protect-enable, 0, 0, 0, level bit 1, level bit 0, enable latch, 0}, so bits 6 to 4 and bit 0 read 0.
- R3: From the cycle the permit pulse is visible until the busy flag has fallen, the status byte reads 0xFF.
- R4: An idle set-enable strobe sets status bit 1 in the next cycle. An idle clear-enable strobe clears it whatever the level of the protect pin.
- R5: A program, erase or status write request made while the enable latch is clear produces no permit and leaves the status byte unchanged.
- R6: With a 17-bit address, protect level 01 guards 0x18000 to 0x1FFFF, level 10 guards 0x10000 to 0x1FFFF and level 11 guards every address. A program or erase to a guarded address gets no permit and leaves the enable latch set. A request to an unguarded address is granted.
- R7: When protect-enable is 1 and the pin is low, a status write is refused, so protect-enable cannot be cleared while the pin stays low. When protect-enable is 0, the pin level has no effect.
- R8: A granted request pulses exactly one permit bit for one cycle, in the cycle after its strobe. Bit 0 is status write, bit 1 is program and bit 2 is erase. A granted status write loads only data bits 7, 3 and 2.
- R9: The enable latch clears on the clock edge where the busy flag is first seen low after a granted cycle.
- R10: Once a status write has been granted, driving the protect pin low does not change the values it stored.
- R11: While busy, all strobes, including set-enable and clear-enable, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wren_i | input | 1 | Set-enable strobe |
| wrdi_i | input | 1 | Clear-enable strobe |
| wrst_i | input | 1 | Status write request, issued when chip select rises |
| wrst_data_i | input | 8 | Data byte of the status write |
| prog_i | input | 1 | Page program request |
| erase_i | input | 1 | Erase request |
| addr_i | input | ADDR_W | Target byte address of a program or erase |
| wp_n_i | input | 1 | Hardware protect pin, active low |
| busy_i | input | 1 | Busy flag from the write sequencer |
| status_o | output | 8 | Status byte for readback |
| permit_o | output | 3 | One-cycle grant: bit 0 status write, bit 1 program, bit 2 erase |
| bp_o | output | 2 | Stored block-protect level |
| wpen_o | output | 1 | Stored protect-enable bit |

## Verification
The assertions assume that the decoder raises at most one strobe in any cycle. They also assume that the sequencer raises busy only after a grant and always lowers it again. Several properties relate a strobe to the status byte one cycle later, and those relations hold only under these conditions. The stimulus drives one strobe per cycle, raises busy only in the cycle after a permit pulse, and holds busy for a few cycles before lowering it. Pin changes are made both between commands and inside a running cycle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   localparam int unsigned PERMIT_W   = 3;
   localparam int unsigned PERMIT_STA = 0;
   localparam int unsigned PERMIT_PRG = 1;
   localparam int unsigned PERMIT_ERS = 2;
   localparam int unsigned STATUS_W   = 8;

   typedef enum logic [1:0] {
      LVL_NONE    = 2'b00,
      LVL_QUARTER = 2'b01,
      LVL_HALF    = 2'b10,
      LVL_ALL     = 2'b11
   } prot_level_t;

   function automatic logic [STATUS_W-1:0] pack_status(
      input logic       busy,
      input logic       wpen,
      input logic [1:0] lvl,
      input logic       wen);
      if (busy) pack_status = '1;
      else      pack_status = {wpen, 3'b000, lvl, wen, 1'b0};
   endfunction
endpackage

// File: rtl/fsr_prot_decode.sv
module fsr_prot_decode
   import fsr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 17,
   parameter bit          PARTIAL = 1'b1
) (
   input  logic [1:0]        lvl_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);
   localparam int unsigned TOP = ADDR_W - 1;

   prot_level_t lvl;
   assign lvl = prot_level_t'(lvl_i);

   generate
      if (PARTIAL) begin : g_partial
         logic [1:0] top_bits;
         assign top_bits = addr_i[TOP -: 2];
         always_comb begin
            unique case (lvl)
               LVL_NONE:    hit_o = 1'b0;
               LVL_QUARTER: hit_o = (top_bits == 2'b11);
               LVL_HALF:    hit_o = top_bits[1];
               default:     hit_o = 1'b1;
            endcase
         end
      end else begin : g_full_only
         assign hit_o = (lvl == LVL_ALL);
      end
   endgenerate
endmodule

// File: rtl/fsr_cfg_reg.sv
module fsr_cfg_reg #(
   parameter bit       RST_WPEN = 1'b0,
   parameter bit [1:0] RST_LVL  = 2'b00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic       wpen_d_i,
   input  logic [1:0] lvl_d_i,
   output logic       wpen_o,
   output logic [1:0] lvl_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wpen_o <= RST_WPEN;
         lvl_o  <= RST_LVL;
      end else if (load_i) begin
         wpen_o <= wpen_d_i;
         lvl_o  <= lvl_d_i;
      end
   end
endmodule

// File: rtl/fsr_wel_seq.sv
module fsr_wel_seq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic start_i,
   input  logic busy_i,
   output logic wen_o,
   output logic pend_o
);
   logic busy_q;
   logic done;

   assign done = pend_o & busy_q & ~busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         pend_o <= 1'b0;
         wen_o  <= 1'b0;
      end else begin
         busy_q <= busy_i;
         if (start_i)   pend_o <= 1'b1;
         else if (done) pend_o <= 1'b0;
         if (done)       wen_o <= 1'b0;
         else if (set_i) wen_o <= 1'b1;
         else if (clr_i) wen_o <= 1'b0;
      end
   end
endmodule

// File: rtl/fsr_guard.sv
module fsr_guard
   import fsr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 17,
   parameter bit          PARTIAL  = 1'b1,
   parameter bit          RST_WPEN = 1'b0,
   parameter bit [1:0]    RST_LVL  = 2'b00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wren_i,
   input  logic                wrdi_i,
   input  logic                wrst_i,
   input  logic [STATUS_W-1:0] wrst_data_i,
   input  logic                prog_i,
   input  logic                erase_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic                wp_n_i,
   input  logic                busy_i,
   output logic [STATUS_W-1:0] status_o,
   output logic [PERMIT_W-1:0] permit_o,
   output logic [1:0]          bp_o,
   output logic                wpen_o
);
   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_addr_w
         $error("fsr_guard: ADDR_W must lie in 2..32");
      end
   endgenerate

   logic wen, pend, rdy, hw_lock, hit;
   logic ok_sta, ok_prg, ok_ers, any_wr, start;
   logic set_wen, clr_wen;
   logic [PERMIT_W-1:0] permit_d;

   assign rdy     = pend | busy_i;
   assign hw_lock = wpen_o & ~wp_n_i;
   assign any_wr  = wrst_i | prog_i | erase_i;

   fsr_prot_decode #(.ADDR_W(ADDR_W), .PARTIAL(PARTIAL)) u_dec (
      .lvl_i  (bp_o),
      .addr_i (addr_i),
      .hit_o  (hit)
   );

   always_comb begin
      ok_sta = 1'b0;
      ok_prg = 1'b0;
      ok_ers = 1'b0;
      if (!rdy && wen) begin
         if (wrst_i)       ok_sta = ~hw_lock;
         else if (prog_i)  ok_prg = ~hit;
         else if (erase_i) ok_ers = ~hit;
      end
   end

   assign start   = ok_sta | ok_prg | ok_ers;
   assign set_wen = ~rdy & ~any_wr & wren_i;
   assign clr_wen = ~rdy & ~any_wr & ~wren_i & wrdi_i;

   always_comb begin
      permit_d             = '0;
      permit_d[PERMIT_STA] = ok_sta;
      permit_d[PERMIT_PRG] = ok_prg;
      permit_d[PERMIT_ERS] = ok_ers;
   end

   fsr_wel_seq u_wel (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (set_wen),
      .clr_i   (clr_wen),
      .start_i (start),
      .busy_i  (busy_i),
      .wen_o   (wen),
      .pend_o  (pend)
   );

   fsr_cfg_reg #(.RST_WPEN(RST_WPEN), .RST_LVL(RST_LVL)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (ok_sta),
      .wpen_d_i (wrst_data_i[7]),
      .lvl_d_i  (wrst_data_i[3:2]),
      .wpen_o   (wpen_o),
      .lvl_o    (bp_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) permit_o <= '0;
      else        permit_o <= permit_d;
   end

   assign status_o = pack_status(rdy, wpen_o, bp_o, wen);
endmodule

// File: rtl/fsr_guard_chk.sv
module fsr_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wren_i,
   input logic       wrdi_i,
   input logic       wrst_i,
   input logic       prog_i,
   input logic       erase_i,
   input logic       wp_n_i,
   input logic       busy_i,
   input logic [7:0] status_o,
   input logic [2:0] permit_o
);
   p_idle_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[0] |-> (status_o[6:4] == 3'b000));

   p_busy_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|permit_o) |-> (status_o == 8'hFF));

   p_wrdi_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wrdi_i && !wren_i && !wrst_i && !prog_i && !erase_i && !status_o[0])
      |=> !status_o[1]);

   p_need_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|permit_o) |-> ($past(status_o[1]) && !$past(status_o[0])));

   p_hw_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wrst_i && !wp_n_i && status_o[7] && !status_o[0]) |=> !permit_o[0]);

   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(permit_o));

   p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|permit_o) |=> (permit_o == 3'b000));

   p_autoclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_i) |=> !status_o[1]);

   p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[0] |=> (permit_o == 3'b000));
endmodule

bind fsr_guard fsr_guard_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wren_i   (wren_i),
   .wrdi_i   (wrdi_i),
   .wrst_i   (wrst_i),
   .prog_i   (prog_i),
   .erase_i  (erase_i),
   .wp_n_i   (wp_n_i),
   .busy_i   (busy_i),
   .status_o (status_o),
   .permit_o (permit_o)
);

// File: tb/fsr_guard_tb.sv
module fsr_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wren_i = 0, wrdi_i = 0, wrst_i = 0, prog_i = 0, erase_i = 0;
   logic [7:0]  wrst_data_i = 8'h00;
   logic [16:0] addr_i = '0;
   logic        wp_n_i = 1'b1, busy_i = 1'b0;
   logic [7:0]  status_o;
   logic [2:0]  permit_o;
   logic [1:0]  bp_o;
   logic        wpen_o;

   int checks = 0, errors = 0, cycles = 0;

   always #4 clk = ~clk;

   fsr_guard u_dut (
      .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
      .wrst_i(wrst_i), .wrst_data_i(wrst_data_i), .prog_i(prog_i),
      .erase_i(erase_i), .addr_i(addr_i), .wp_n_i(wp_n_i), .busy_i(busy_i),
      .status_o(status_o), .permit_o(permit_o), .bp_o(bp_o), .wpen_o(wpen_o)
   );

   // behavioural reference
   bit       m_wen, m_pend, m_wpen, m_busy_q;
   bit [1:0] m_lvl;
   bit [2:0] m_perm;

   function automatic bit guarded(bit [1:0] lvl, logic [16:0] a);
      case (lvl)
         2'd0: return 1'b0;
         2'd1: return a >= 17'h18000;
         2'd2: return a >= 17'h10000;
         default: return 1'b1;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wen = 0; m_pend = 0; m_wpen = 0; m_busy_q = 0; m_lvl = 0; m_perm = 0;
      end else begin
         bit [2:0] np;
         np = 3'b000;
         if (m_pend && m_busy_q && !busy_i) begin
            m_pend = 0; m_wen = 0;
         end else if (!(m_pend || busy_i)) begin
            if (wrst_i) begin
               if (m_wen && !(m_wpen && !wp_n_i)) begin
                  np = 3'b001; m_pend = 1;
                  m_wpen = wrst_data_i[7]; m_lvl = wrst_data_i[3:2];
               end
            end else if (prog_i) begin
               if (m_wen && !guarded(m_lvl, addr_i)) begin np = 3'b010; m_pend = 1; end
            end else if (erase_i) begin
               if (m_wen && !guarded(m_lvl, addr_i)) begin np = 3'b100; m_pend = 1; end
            end else if (wren_i) m_wen = 1;
            else if (wrdi_i) m_wen = 0;
         end
         m_busy_q = busy_i;
         m_perm = np;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      #3;
      if (rst_n) begin
         logic [7:0] es;
         es = (m_pend || busy_i) ? 8'hFF : {m_wpen, 3'b000, m_lvl, m_wen, 1'b0};
         chk(status_o === es, "R2 status vs model", status_o, es);
         chk(permit_o === m_perm, "R8 permit vs model", permit_o, m_perm);
         chk({wpen_o, bp_o} === {m_wpen, m_lvl}, "R8 protect outputs vs model",
             {wpen_o, bp_o}, {m_wpen, m_lvl});
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 20000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic idle();
      @(negedge clk);
      wren_i = 0; wrdi_i = 0; wrst_i = 0; prog_i = 0; erase_i = 0;
   endtask

   task automatic cmd(input int kind, input logic [16:0] a, input logic [7:0] d);
      idle();
      addr_i = a; wrst_data_i = d;
      case (kind)
         0: wren_i = 1;
         1: wrdi_i = 1;
         2: wrst_i = 1;
         3: prog_i = 1;
         default: erase_i = 1;
      endcase
   endtask

   task automatic see(input logic [7:0] es, input logic [2:0] ep, input string tag);
      idle(); #3;
      chk(status_o === es, tag, status_o, es);
      chk(permit_o === ep, tag, permit_o, ep);
   endtask

   // finish a granted cycle: busy for n cycles, then low
   task automatic finish_cycle(input int n, input bit drop_pin);
      for (int i = 0; i < n; i++) begin
         idle(); busy_i = 1;
         if (drop_pin && i == 1) wp_n_i = 0;
         #3 chk(status_o === 8'hFF, "R3 busy reads ones", status_o, 8'hFF);
      end
      idle(); busy_i = 0;
      #3 chk(status_o === 8'hFF, "R3 ones until fall seen", status_o, 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      #3 chk(status_o === 8'h00, "R1 reset status", status_o, 8'h00);
      chk(permit_o === 3'b000, "R1 reset permit", permit_o, 3'b000);

      cmd(3, 17'h00100, 8'h00); see(8'h00, 3'b000, "R5 program without latch");
      cmd(2, 17'h0, 8'h8C);     see(8'h00, 3'b000, "R5 status write without latch");
      cmd(0, 17'h0, 8'h00);     see(8'h02, 3'b000, "R4 set-enable");

      cmd(2, 17'h0, 8'hFC);     see(8'hFF, 3'b001, "R8 status write permit");
      finish_cycle(3, 0);
      see(8'h8C, 3'b000, "R9 latch cleared, R8 only bits 7/3/2 stored");

      wp_n_i = 0;
      cmd(0, 17'h0, 8'h00);     see(8'h8E, 3'b000, "R4 set-enable with pin low");
      cmd(2, 17'h0, 8'h00);     see(8'h8E, 3'b000, "R7 hw lock refuses status write");
      cmd(1, 17'h0, 8'h00);     see(8'h8C, 3'b000, "R4 clear-enable with pin low");

      wp_n_i = 1;
      cmd(0, 17'h0, 8'h00);
      cmd(2, 17'h0, 8'h04);     see(8'hFF, 3'b001, "R10 status write granted");
      cmd(0, 17'h0, 8'h00);     #3 chk(permit_o === 3'b000, "R11 set-enable ignored", permit_o, 0);
      busy_i = 1;
      cmd(3, 17'h00010, 8'h00); #3 chk(permit_o === 3'b000, "R11 program ignored", permit_o, 0);
      finish_cycle(2, 1);
      see(8'h04, 3'b000, "R10 pin drop after grant no effect, R11 latch still clear");

      cmd(0, 17'h0, 8'h00);
      cmd(3, 17'h18000, 8'h00); see(8'h06, 3'b000, "R6 quarter guard refuses 0x18000");
      cmd(3, 17'h17FFF, 8'h00); see(8'hFF, 3'b010, "R6 program below quarter granted");
      finish_cycle(2, 0);       see(8'h04, 3'b000, "R9 cleared after program");

      cmd(0, 17'h0, 8'h00);
      cmd(2, 17'h0, 8'h08);     see(8'hFF, 3'b001, "R7 pin low ignored when enable bit 0");
      finish_cycle(2, 0);
      cmd(0, 17'h0, 8'h00);
      cmd(4, 17'h10000, 8'h00); see(8'h0A, 3'b000, "R6 half guard refuses erase 0x10000");
      cmd(4, 17'h0FFFF, 8'h00); see(8'hFF, 3'b100, "R6 erase below half granted");
      finish_cycle(2, 0);

      cmd(0, 17'h0, 8'h00);
      cmd(2, 17'h0, 8'h0C);
      finish_cycle(2, 0);
      cmd(0, 17'h0, 8'h00);
      cmd(3, 17'h00000, 8'h00); see(8'h0E, 3'b000, "R6 full guard refuses 0x00000");
      cmd(4, 17'h1FFFF, 8'h00); see(8'h0E, 3'b000, "R6 full guard refuses erase top");

      idle(); idle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule